// File: doc/BRIEF.md
# Dual-Mode 8-Bit Interval and PWM Timer

This block is an 8-bit up-counter paired with a compare register. Each count step is paced by a one-cycle strobe from an external prescaler. The counter runs in one of two functions, chosen by a mode input.

- **Interval mode.** The counter reloads to zero after it reaches the compare value. A sticky flag records each match, and a level interrupt line rises while that flag and an enable input are both high.
- **PWM mode.** The counter wraps freely from 0xFF to 0x00. An output pin is high while the count is below the compare value. No flag is ever raised in this mode.

Software writes the compare register through a write strobe. It clears the flag by writing 0 to it.

A three-state controller sequences the counter:

| State | Meaning |
|---|---|
| `ST_STOPPED` | Counter frozen, PWM pin low |
| `ST_RUN_IVL` | Interval counting |
| `ST_RUN_PWM` | Free-running PWM counting |

| Transition | Condition |
|---|---|
| Start-interval: `ST_STOPPED` to `ST_RUN_IVL` | `run_i` high and `pwm_mode_i` low |
| Start-PWM: `ST_STOPPED` to `ST_RUN_PWM` | `run_i` high and `pwm_mode_i` high |
| Mode-swap | Moves between `ST_RUN_IVL` and `ST_RUN_PWM` whenever `pwm_mode_i` changes while running; the count is kept |
| Halt | Returns any running state to `ST_STOPPED` when `run_i` drops |

On a start transition the counter is cleared to 0x00.

Top module: `ivl_pwm_timer`

## Requirements
- R1: After reset, `count_o` is 0x00 and `flag_o`, `irq_o` and `pwm_o` are 0.
- R2: On the clock where `run_i` is first seen high while stopped, the counter is cleared to 0x00 and that cycle's tick is ignored. While running, the counter moves by one on each cycle with `tick_i` high and holds otherwise.
- R3: In interval mode, a tick taken while `count_o` equals the compare value sets `flag_o` to 1 and reloads the counter to 0x00, so a match recurs every compare+1 ticks.
- R4: The flag is set on a match whether or not `irq_en_i` is high. `irq_o` is high exactly while `flag_o` is 1 and `irq_en_i` is 1, with no clock delay, so raising the enable with the flag already set raises `irq_o` at once.
- R5: `flag_o` stays 1 until a write (`flag_we_i`=1) with `flag_wdata_i`=0. Writing 1 changes nothing. A hardware set in the same cycle as a clearing write leaves the flag at 1.
- R6: With `run_i` low, no flag is set even when the count equals the compare value, and the counter holds its value.
- R7: In PWM mode the counter goes from 0xFF to 0x00 on a tick, `pwm_o` is 1 exactly while `count_o` is below the compare value, and `flag_o` is never set.
- R8: `pwm_o` is 0 while the timer is stopped and while it runs in interval mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-clock strobe from prescaler |
| run_i | input | 1 | Run control (1 = count) |
| pwm_mode_i | input | 1 | 0 = interval function, 1 = PWM function |
| irq_en_i | input | 1 | Interrupt enable |
| cmp_we_i | input | 1 | Compare register write strobe |
| cmp_wdata_i | input | 8 | Compare register write data |
| flag_we_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 1 | Flag write data (only 0 acts) |
| count_o | output | 8 | Current counter value |
| flag_o | output | 1 | Sticky match flag |
| irq_o | output | 1 | Level interrupt request |
| pwm_o | output | 1 | PWM output pin |

## Verification
Interval counting is driven with ticks on every cycle and with sparse ticks. This separates tick-paced advance from clock-paced advance, and it exposes an off-by-one in the reload period. The flag is exercised in four ways:

- raising the enable late;
- writing 1 to the flag;
- clearing it on the exact match tick;
- stopping the counter on a matching value.

Together these tell a sticky, set-priority flag apart from one that is pulsed, clearable by any write, or set while stopped. PWM runs span several wraps with a mid-range compare value and with a compare value of zero. This separates a below-compare duty from a less-or-equal duty, and shows that no interrupt leaks out of PWM mode.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
    typedef enum logic [1:0] {
        ST_STOPPED = 2'd0,
        ST_RUN_IVL = 2'd1,
        ST_RUN_PWM = 2'd2
    } ipt_state_e;
endpackage

// File: rtl/ipt_ctrl.sv
module ipt_ctrl
    import ipt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic pwm_mode_i,
    input  logic tick_i,
    output logic cnt_clr_o,
    output logic cnt_adv_o,
    output logic ivl_act_o,
    output logic pwm_act_o
);
    ipt_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: if (run_i) state_d = pwm_mode_i ? ST_RUN_PWM : ST_RUN_IVL;
            ST_RUN_IVL: if (!run_i) state_d = ST_STOPPED;
                        else if (pwm_mode_i) state_d = ST_RUN_PWM;
            ST_RUN_PWM: if (!run_i) state_d = ST_STOPPED;
                        else if (!pwm_mode_i) state_d = ST_RUN_IVL;
            default:    state_d = ST_STOPPED;
        endcase
    end

    // outputs
    always_comb begin
        cnt_clr_o = 1'b0;
        cnt_adv_o = 1'b0;
        ivl_act_o = 1'b0;
        pwm_act_o = 1'b0;
        unique case (state_q)
            ST_STOPPED: cnt_clr_o = run_i;
            ST_RUN_IVL: begin
                ivl_act_o = 1'b1;
                cnt_adv_o = run_i & tick_i;
            end
            ST_RUN_PWM: begin
                pwm_act_o = 1'b1;
                cnt_adv_o = run_i & tick_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ipt_counter.sv
module ipt_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         adv_i,
    input  logic         ivl_i,
    input  logic         cmp_we_i,
    input  logic [W-1:0] cmp_wdata_i,
    output logic [W-1:0] count_o,
    output logic [W-1:0] cmp_o,
    output logic         match_o
);
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] count_q, cmp_q;
    logic         equal;

    assign equal   = (count_q == cmp_q);
    assign match_o = adv_i & ivl_i & equal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= ZERO;
        end else if (clr_i) begin
            count_q <= ZERO;
        end else if (adv_i) begin
            if (ivl_i && equal) count_q <= ZERO;
            else                count_q <= count_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cmp_q <= ZERO;
        else if (cmp_we_i) cmp_q <= cmp_wdata_i;
    end

    assign count_o = count_q;
    assign cmp_o   = cmp_q;
endmodule

// File: rtl/ipt_flag.sv
module ipt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic we_i,
    input  logic wdata_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                flag_q <= 1'b0;
        else if (set_i)            flag_q <= 1'b1;
        else if (we_i && !wdata_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/ivl_pwm_timer.sv
module ivl_pwm_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         run_i,
    input  logic         pwm_mode_i,
    input  logic         irq_en_i,
    input  logic         cmp_we_i,
    input  logic [W-1:0] cmp_wdata_i,
    input  logic         flag_we_i,
    input  logic         flag_wdata_i,
    output logic [W-1:0] count_o,
    output logic         flag_o,
    output logic         irq_o,
    output logic         pwm_o
);
    logic         cnt_clr, cnt_adv, ivl_act, pwm_act, match;
    logic [W-1:0] cmp_val;

    ipt_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run_i),
        .pwm_mode_i (pwm_mode_i),
        .tick_i     (tick_i),
        .cnt_clr_o  (cnt_clr),
        .cnt_adv_o  (cnt_adv),
        .ivl_act_o  (ivl_act),
        .pwm_act_o  (pwm_act)
    );

    ipt_counter #(.W(W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (cnt_clr),
        .adv_i       (cnt_adv),
        .ivl_i       (ivl_act),
        .cmp_we_i    (cmp_we_i),
        .cmp_wdata_i (cmp_wdata_i),
        .count_o     (count_o),
        .cmp_o       (cmp_val),
        .match_o     (match)
    );

    ipt_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (match),
        .we_i    (flag_we_i),
        .wdata_i (flag_wdata_i),
        .flag_o  (flag_o)
    );

    assign irq_o = flag_o & irq_en_i;
    assign pwm_o = pwm_act & (count_o < cmp_val);
endmodule

// File: rtl/ipt_checker.sv
module ipt_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick_i,
    input logic         run_i,
    input logic         pwm_mode_i,
    input logic         irq_en_i,
    input logic         flag_we_i,
    input logic         flag_wdata_i,
    input logic [W-1:0] count_o,
    input logic         flag_o,
    input logic         irq_o,
    input logic         pwm_o
);
    localparam logic [W-1:0] MAXV = '1;

    // R2: running without a tick holds the count
    a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i) && !tick_i) |=> $stable(count_o));

    // R4: enable rising with flag set raises irq at once
    a_r4_irq_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_en_i) && flag_o) |-> irq_o);

    // R5: flag stays set unless cleared by a write of 0
    a_r5_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !(flag_we_i && !flag_wdata_i)) |=> flag_o);

    // R6: stopped cycles never set the flag
    a_r6_no_set_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !flag_o) |=> !flag_o);

    // R7: PWM mode never sets the flag
    a_r7_pwm_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode_i && $past(pwm_mode_i) && !flag_o) |=> !flag_o);

    // R7: free wrap at the top in PWM mode
    a_r7_pwm_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == MAXV && tick_i && run_i && $past(run_i)
         && pwm_mode_i && $past(pwm_mode_i)) |=> (count_o == '0));

    // R8: PWM pin low while stopped
    a_r8_pwm_low_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(run_i)) |-> !pwm_o);

    // R8: PWM pin low in interval mode
    a_r8_pwm_low_ivl: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(pwm_mode_i)) |-> !pwm_o);
endmodule

bind ivl_pwm_timer ipt_checker #(.W(W)) u_ipt_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .run_i        (run_i),
    .pwm_mode_i   (pwm_mode_i),
    .irq_en_i     (irq_en_i),
    .flag_we_i    (flag_we_i),
    .flag_wdata_i (flag_wdata_i),
    .count_o      (count_o),
    .flag_o       (flag_o),
    .irq_o        (irq_o),
    .pwm_o        (pwm_o)
);

// File: tb/test_ivl_pwm_timer.sv
module test_ivl_pwm_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0, run_i = 1'b0, pwm_mode_i = 1'b0, irq_en_i = 1'b0;
    logic       cmp_we_i = 1'b0, flag_we_i = 1'b0, flag_wdata_i = 1'b0;
    logic [7:0] cmp_wdata_i = 8'h00;
    logic [7:0] count_o;
    logic       flag_o, irq_o, pwm_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        string      tag;
        logic [7:0] cnt;
        logic       flag;
        logic       irq;
        logic       pwm;
    } exp_t;
    exp_t exp_q[$];

    // reference state, built from the requirements
    bit       m_act  = 1'b0;
    bit       m_mode = 1'b0;
    bit [7:0] m_cnt  = 8'h00;
    bit       m_flag = 1'b0;
    bit [7:0] m_cmp  = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    ivl_pwm_timer i_ivl_pwm_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run_i),
        .pwm_mode_i(pwm_mode_i), .irq_en_i(irq_en_i), .cmp_we_i(cmp_we_i),
        .cmp_wdata_i(cmp_wdata_i), .flag_we_i(flag_we_i), .flag_wdata_i(flag_wdata_i),
        .count_o(count_o), .flag_o(flag_o), .irq_o(irq_o), .pwm_o(pwm_o)
    );

    // driver: apply inputs, predict, push expectation
    task automatic step(input string tag, input bit run, input bit mode, input bit tk,
                        input bit en, input bit fwe, input bit fwd,
                        input bit cwe, input bit [7:0] cwd);
        bit set;
        exp_t e;
        @(negedge clk);
        run_i = run; pwm_mode_i = mode; tick_i = tk; irq_en_i = en;
        flag_we_i = fwe; flag_wdata_i = fwd; cmp_we_i = cwe; cmp_wdata_i = cwd;
        set = 1'b0;
        if (!m_act) begin
            if (run) begin m_act = 1'b1; m_cnt = 8'h00; m_mode = mode; end
        end else if (!run) begin
            m_act = 1'b0;
        end else begin
            if (tk) begin
                if (!m_mode && m_cnt == m_cmp) begin set = 1'b1; m_cnt = 8'h00; end
                else m_cnt = m_cnt + 8'h01;
            end
            m_mode = mode;
        end
        if (set) m_flag = 1'b1;
        else if (fwe && !fwd) m_flag = 1'b0;
        if (cwe) m_cmp = cwd;
        e.tag  = tag;
        e.cnt  = m_cnt;
        e.flag = m_flag;
        e.irq  = m_flag & en;
        e.pwm  = m_act & m_mode & (m_cnt < m_cmp);
        exp_q.push_back(e);
    endtask

    task automatic idle(input string tag, input bit run, input bit mode, input bit tk, input bit en);
        step(tag, run, mode, tk, en, 1'b0, 1'b0, 1'b0, 8'h00);
    endtask

    // monitor: compare after each active edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (count_o !== e.cnt || flag_o !== e.flag || irq_o !== e.irq || pwm_o !== e.pwm) begin
                errors++;
                $display("FAIL %s: cnt/flag/irq/pwm actual=%h/%b/%b/%b expected=%h/%b/%b/%b",
                         e.tag, count_o, flag_o, irq_o, pwm_o, e.cnt, e.flag, e.irq, e.pwm);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        checks++;
        if (count_o !== 8'h00 || flag_o !== 1'b0 || irq_o !== 1'b0 || pwm_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: reset outputs actual=%h/%b/%b/%b expected=00/0/0/0",
                     count_o, flag_o, irq_o, pwm_o);
        end

        // interval, compare 3, enable off: flag still sets (R3, R4)
        step("R3", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd3);
        idle("R2", 1'b1, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 9; i++) idle("R3", 1'b1, 1'b0, 1'b1, 1'b0);
        // sparse ticks: hold between ticks (R2)
        for (int i = 0; i < 8; i++) idle("R2", 1'b1, 1'b0, i[0], 1'b0);
        // late enable raises irq at once (R4)
        idle("R4", 1'b1, 1'b0, 1'b0, 1'b1);
        // write 1 has no effect (R5)
        step("R5", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
        // clear by writing 0 (R5)
        step("R5", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
        // run up to the match value, then clear on the match tick: set wins (R5)
        while (m_cnt != m_cmp) idle("R3", 1'b1, 1'b0, 1'b1, 1'b1);
        step("R5", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
        step("R5", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
        // stop on the matching value: no flag, count frozen (R6)
        while (m_cnt != m_cmp) idle("R3", 1'b1, 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 4; i++) idle("R6", 1'b0, 1'b0, 1'b1, 1'b1);
        // restart from zero (R2)
        for (int i = 0; i < 3; i++) idle("R2", 1'b1, 1'b0, 1'b1, 1'b1);
        // interval pin stays low even with count below compare (R8)
        idle("R8", 1'b1, 1'b0, 1'b1, 1'b1);

        // PWM, compare 0x40, through several wraps (R7)
        step("R7", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h40);
        for (int i = 0; i < 600; i++) idle("R7", 1'b1, 1'b1, 1'b1, 1'b1);
        // stopped in PWM: pin low (R8)
        for (int i = 0; i < 3; i++) idle("R8", 1'b0, 1'b1, 1'b1, 1'b1);
        // compare zero: pin never high (R7)
        step("R7", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
        for (int i = 0; i < 300; i++) idle("R7", 1'b1, 1'b1, 1'b1, 1'b1);
        // compare max with sparse ticks (R7)
        step("R7", 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF);
        for (int i = 0; i < 520; i++) idle("R7", 1'b1, 1'b1, i[0], 1'b1);

        // interval with compare 0: every tick matches (R3)
        step("R3", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
        idle("R3", 1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            idle("R3", 1'b1, 1'b0, 1'b1, 1'b0);
            step("R5", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
        end

        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule